// File: doc/BRIEF.md
# Programmable Memory-to-Memory DMA Channel

This block is one DMA channel that copies a programmed number of 16-bit or 32-bit units from a source region to a destination region. It does this over a simple synchronous bus master port. Software loads a source pointer, a destination pointer and a 32-bit control word. Setting the enable bit in the control word while it was clear arms the channel. Arming copies the programmed addresses into working pointers and latches the address-walk and start-timing fields. Depending on the start field, the transfer then either begins at once or waits for a matching trigger pulse from outside.

While a burst runs, the channel holds the host processor in a halted state. For each unit it makes one read access, then one write access, and each access uses a request/grant handshake. When the last unit is written, the channel can raise a one-cycle interrupt. It also clears its own enable bit, unless repeat is selected. A FIFO-feeding start mode splits a long transfer into bursts with a capped length. After each burst the processor is released, and the next trigger resumes the transfer from the stored remaining count.

Top module: `dmac_channel`

## Requirements
- R1: Register writes use `cfg_sel` 0 for the source pointer, 1 for the destination pointer and 2 for the control word. Pointers and mode fields are latched only when bit 31 of the control word goes from 0 to 1 while the channel is idle. A control write while bit 31 is already set does not relatch them.
- R2: Bits 24:23 set how the source pointer walks and bits 22:21 set how the destination pointer walks. 00 counts up, 01 counts down, 10 holds still, and 11 counts up and also reloads the pointer from the programmed address at every start.
- R3: Bit 26 set selects 32-bit units with a pointer stride of 4. Bit 26 clear selects 16-bit units with a stride of 2. `bus_size32` shows bit 26.
- R4: The unit count is bits CNT_W-1:0 of the control word, and higher bits are ignored. A count of zero means 2^CNT_W units.
- R5: Bits 29:27 choose the start timing. 0 starts right after arming. Any other value k starts only on a `trig_i` pulse with `trig_sel` equal to k, and pulses with another `trig_sel` value are ignored.
- R6: With start timing 7, each burst moves at most BURST_CAP (112) units. If units remain, the channel goes idle, keeps the remaining count and continues on the next matching trigger.
- R7: When the remaining count reaches zero, bit 31 is cleared unless bit 25 (repeat) is set. If bit 30 is set, `irq` pulses high for exactly one cycle.
- R8: A start request that arrives while a burst is running is ignored and does not change the amount moved.
- R9: `cpu_halt` is high from the first access of a burst until its last write is granted, and low at all other times. Bus requests occur only while it is high.
- R10: Each unit is a read from the source pointer followed by a write to the destination pointer. The write carries the 32 read bits unchanged. A request holds its address and direction until it is granted.
- R11: A start with no transfer pending loads a fresh count from the control word, so a repeated channel moves the full count again on each trigger. A resumed burst uses the stored remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 control |
| cfg_wdata | input | 32 | Register write data |
| ctrl_rd | output | 32 | Current control word |
| trig_i | input | 1 | External start trigger pulse |
| trig_sel | input | 3 | Start timing code of the trigger |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write access, 0 = read access |
| bus_addr | output | ADDR_W | Access address |
| bus_wdata | output | 32 | Write data |
| bus_size32 | output | 1 | 1 = 32-bit unit, 0 = 16-bit unit |
| bus_gnt | input | 1 | Access accepted this cycle |
| bus_rdata | input | 32 | Read data, valid with grant on a read |
| cpu_halt | output | 1 | Host processor stall |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The hardest situation to reach from the ports is a start request arriving in the middle of a running FIFO-mode burst. It must arrive after the channel has armed, triggered and moved part of the capped burst. The stimulus fires the first matching trigger, waits ten cycles into the 112-unit burst and pulses the same trigger again. It then counts that exactly 112 units moved and that the next two triggers finish the remaining count. A second hard case is a repeated channel with a reloading source pointer and a continuing destination pointer. Two triggers are issued, and every read and write address of the second run is compared against the bench's pointer model.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  // control word bit positions
  localparam int unsigned CB_EN     = 31;
  localparam int unsigned CB_IRQ    = 30;
  localparam int unsigned CB_TRG_HI = 29;
  localparam int unsigned CB_TRG_LO = 27;
  localparam int unsigned CB_WIDE   = 26;
  localparam int unsigned CB_RPT    = 25;
  localparam int unsigned CB_SRC_HI = 24;
  localparam int unsigned CB_SRC_LO = 23;
  localparam int unsigned CB_DST_HI = 22;
  localparam int unsigned CB_DST_LO = 21;

  typedef enum logic [1:0] {
    PM_UP        = 2'b00,
    PM_DOWN      = 2'b01,
    PM_HOLD      = 2'b10,
    PM_UP_RELOAD = 2'b11
  } ptr_mode_e;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam logic [2:0] TRG_NOW  = 3'd0;
  localparam logic [2:0] TRG_FIFO = 3'd7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              busy,
  input  logic              done_clr,
  output logic [31:0]       ctrl,
  output logic [ADDR_W-1:0] prog_src,
  output logic [ADDR_W-1:0] prog_dst,
  output ptr_mode_e         src_mode,
  output ptr_mode_e         dst_mode,
  output logic [2:0]        trg_mode,
  output logic              go_now,
  output logic              arm
);
  logic [31:0]       ctrl_q, ctrl_d;
  logic [ADDR_W-1:0] src_q, src_d, dst_q, dst_d;
  ptr_mode_e         smode_q, smode_d, dmode_q, dmode_d;
  logic [2:0]        trg_q, trg_d;
  logic              now_q, now_d;
  logic              wr_ctrl;

  assign wr_ctrl = cfg_we && (cfg_sel == SEL_CTRL);
  // enable rising edge, accepted only while no burst runs
  assign arm = wr_ctrl && !ctrl_q[CB_EN] && cfg_wdata[CB_EN] && !busy;

  always_comb begin
    ctrl_d  = ctrl_q;
    src_d   = src_q;
    dst_d   = dst_q;
    smode_d = smode_q;
    dmode_d = dmode_q;
    trg_d   = trg_q;
    now_d   = 1'b0;
    if (done_clr) ctrl_d[CB_EN] = 1'b0;
    if (wr_ctrl) ctrl_d = cfg_wdata;
    if (cfg_we && (cfg_sel == SEL_SRC)) src_d = cfg_wdata[ADDR_W-1:0];
    if (cfg_we && (cfg_sel == SEL_DST)) dst_d = cfg_wdata[ADDR_W-1:0];
    if (arm) begin
      smode_d = ptr_mode_e'(cfg_wdata[CB_SRC_HI:CB_SRC_LO]);
      dmode_d = ptr_mode_e'(cfg_wdata[CB_DST_HI:CB_DST_LO]);
      trg_d   = cfg_wdata[CB_TRG_HI:CB_TRG_LO];
      now_d   = (cfg_wdata[CB_TRG_HI:CB_TRG_LO] == TRG_NOW);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      smode_q <= PM_UP;
      dmode_q <= PM_UP;
      trg_q   <= TRG_NOW;
      now_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      smode_q <= smode_d;
      dmode_q <= dmode_d;
      trg_q   <= trg_d;
      now_q   <= now_d;
    end
  end

  assign ctrl     = ctrl_q;
  assign prog_src = src_q;
  assign prog_dst = dst_q;
  assign src_mode = smode_q;
  assign dst_mode = dmode_q;
  assign trg_mode = trg_q;
  assign go_now   = now_q;

  // R7: completion without repeat drops the enable bit
  a_r7_enable_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr && !wr_ctrl) |=> !ctrl_q[CB_EN]);

  // R1: control rewrite with enable already set keeps the latched modes
  a_r1_no_relatch: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && ctrl_q[CB_EN]) |=> ($stable(smode_q) && $stable(dmode_q) && $stable(trg_q)));
endmodule

// File: rtl/dmac_ptr.sv
module dmac_ptr
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              restart,
  input  logic              advance,
  input  ptr_mode_e         mode,
  input  logic              wide,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] ptr
);
  localparam logic [ADDR_W-1:0] STEP_HALF = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(4);

  logic [ADDR_W-1:0] ptr_q, ptr_d, stride;

  assign stride = wide ? STEP_WORD : STEP_HALF;

  always_comb begin
    ptr_d = ptr_q;
    if (load || (restart && (mode == PM_UP_RELOAD))) begin
      ptr_d = base;
    end else if (advance) begin
      unique case (mode)
        PM_DOWN: ptr_d = ptr_q - stride;
        PM_HOLD: ptr_d = ptr_q;
        default: ptr_d = ptr_q + stride;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R2: a fixed pointer never moves on a unit
  a_r2_fixed_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && !restart && (mode == PM_HOLD)) |=> $stable(ptr_q));

  // R3: an upward pointer moves by the unit size
  a_r3_stride_up: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && !restart && (mode == PM_UP)) |=>
      ((ptr_q - $past(ptr_q)) == ($past(wide) ? ADDR_W'(4) : ADDR_W'(2))));
endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
  import dmac_pkg::*;
#(
  parameter int CNT_W     = 21,
  parameter int BURST_CAP = 112,
  parameter int ADDR_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_now,
  input  logic              trig_i,
  input  logic [2:0]        trig_sel,
  input  logic              enabled,
  input  logic [2:0]        trg_mode,
  input  logic [CNT_W-1:0]  cnt_field,
  input  logic              irq_en,
  input  logic              rpt,
  input  logic [ADDR_W-1:0] src_ptr,
  input  logic [ADDR_W-1:0] dst_ptr,
  input  logic              bus_gnt,
  input  logic [31:0]       bus_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  output logic              busy,
  output logic              irq,
  output logic              start_go,
  output logic              advance,
  output logic              done_clr
);
  localparam int RCW = CNT_W + 1;
  localparam logic [RCW-1:0] CAP  = RCW'(BURST_CAP);
  localparam logic [RCW-1:0] FULL = RCW'(1) << CNT_W;
  localparam logic [RCW-1:0] ONE  = RCW'(1);

  xfer_state_e    st_q, st_d;
  logic [RCW-1:0] rem_q, rem_d, iter_q, iter_d, fresh, base;
  logic [31:0]    data_q;
  logic           data_en;
  logic           open_q, open_d;
  logic           irq_q, irq_d;
  logic           trig_hit, start_req, unit_done, last_iter, last_unit;

  assign trig_hit  = trig_i && enabled && (trg_mode != TRG_NOW) && (trig_sel == trg_mode);
  assign start_req = go_now || trig_hit;
  assign start_go  = start_req && (st_q == ST_IDLE);
  assign unit_done = (st_q == ST_WRITE) && bus_gnt;
  assign last_iter = (iter_q == ONE);
  assign last_unit = (rem_q == ONE);
  assign fresh     = (cnt_field == '0) ? FULL : {1'b0, cnt_field};
  assign base      = open_q ? rem_q : fresh;
  assign data_en   = (st_q == ST_READ) && bus_gnt;

  always_comb begin
    st_d   = st_q;
    rem_d  = rem_q;
    iter_d = iter_q;
    open_d = open_q;
    irq_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_go) begin
          rem_d  = base;
          iter_d = ((trg_mode == TRG_FIFO) && (base > CAP)) ? CAP : base;
          open_d = 1'b1;
          st_d   = ST_READ;
        end
      end
      ST_READ: begin
        if (bus_gnt) st_d = ST_WRITE;
      end
      ST_WRITE: begin
        if (bus_gnt) begin
          rem_d  = rem_q - ONE;
          iter_d = iter_q - ONE;
          st_d   = last_iter ? ST_IDLE : ST_READ;
          if (last_unit) begin
            open_d = 1'b0;
            irq_d  = irq_en;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      iter_q <= '0;
      open_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      rem_q  <= rem_d;
      iter_q <= iter_d;
      open_q <= open_d;
      irq_q  <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= bus_rdata;
  end

  assign advance   = unit_done;
  assign done_clr  = unit_done && last_unit && !rpt;
  assign busy      = (st_q != ST_IDLE);
  assign bus_req   = (st_q != ST_IDLE);
  assign bus_we    = (st_q == ST_WRITE);
  assign bus_addr  = (st_q == ST_WRITE) ? dst_ptr : src_ptr;
  assign bus_wdata = data_q;
  assign irq       = irq_q;

  // R10: an ungranted request keeps its address and direction
  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_we) && $stable(bus_addr)));

  // R7: the interrupt is a single-cycle pulse
  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R8: a start request during a burst never raises the remaining count
  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_req) |=> (rem_q <= $past(rem_q)));

  // R6: burst counter stays within the remaining count and the cap
  a_r6_burst_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((iter_q != '0) && (iter_q <= rem_q) &&
              ((trg_mode != TRG_FIFO) || (iter_q <= CAP))));

  // R9: the halt is released only with the burst counter exhausted
  a_r9_halt_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (iter_q == '0));
endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
  import dmac_pkg::*;
#(
  parameter int CNT_W     = 21,
  parameter int BURST_CAP = 112,
  parameter int ADDR_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       ctrl_rd,
  input  logic              trig_i,
  input  logic [2:0]        trig_sel,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  output logic              bus_size32,
  input  logic              bus_gnt,
  input  logic [31:0]       bus_rdata,
  output logic              cpu_halt,
  output logic              irq
);
  localparam int N_PTR = 2;

  logic [31:0]       ctrl;
  logic [ADDR_W-1:0] prog_src, prog_dst;
  ptr_mode_e         src_mode, dst_mode;
  logic [2:0]        trg_mode;
  logic              go_now, arm, busy, done_clr, start_go, advance;

  ptr_mode_e         p_mode [N_PTR];
  logic [ADDR_W-1:0] p_base [N_PTR];
  logic [ADDR_W-1:0] p_val  [N_PTR];

  dmac_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .busy      (busy),
    .done_clr  (done_clr),
    .ctrl      (ctrl),
    .prog_src  (prog_src),
    .prog_dst  (prog_dst),
    .src_mode  (src_mode),
    .dst_mode  (dst_mode),
    .trg_mode  (trg_mode),
    .go_now    (go_now),
    .arm       (arm)
  );

  assign p_mode[0] = src_mode;
  assign p_mode[1] = dst_mode;
  assign p_base[0] = prog_src;
  assign p_base[1] = prog_dst;

  for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
    dmac_ptr #(.ADDR_W(ADDR_W)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (arm),
      .restart (start_go),
      .advance (advance),
      .mode    (p_mode[g]),
      .wide    (ctrl[CB_WIDE]),
      .base    (p_base[g]),
      .ptr     (p_val[g])
    );
  end

  dmac_seq #(.CNT_W(CNT_W), .BURST_CAP(BURST_CAP), .ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_now    (go_now),
    .trig_i    (trig_i),
    .trig_sel  (trig_sel),
    .enabled   (ctrl[CB_EN]),
    .trg_mode  (trg_mode),
    .cnt_field (ctrl[CNT_W-1:0]),
    .irq_en    (ctrl[CB_IRQ]),
    .rpt       (ctrl[CB_RPT]),
    .src_ptr   (p_val[0]),
    .dst_ptr   (p_val[1]),
    .bus_gnt   (bus_gnt),
    .bus_rdata (bus_rdata),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .busy      (busy),
    .irq       (irq),
    .start_go  (start_go),
    .advance   (advance),
    .done_clr  (done_clr)
  );

  assign ctrl_rd    = ctrl;
  assign bus_size32 = ctrl[CB_WIDE];
  assign cpu_halt   = busy;
endmodule

// File: tb/test_dmac_channel.sv
`timescale 1ns/1ps
module test_dmac_channel;
  localparam int CW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] ctrl_rd;
  logic        trig_i = 1'b0;
  logic [2:0]  trig_sel = 3'd0;
  logic        bus_req, bus_we, bus_size32, cpu_halt, irq;
  logic [31:0] bus_addr, bus_wdata;
  logic        bus_gnt = 1'b0;
  logic [31:0] bus_rdata = '0;

  always #10 clk = ~clk;

  dmac_channel #(.CNT_W(CW), .BURST_CAP(112), .ADDR_W(32)) i_dmac_channel (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ctrl_rd(ctrl_rd), .trig_i(trig_i), .trig_sel(trig_sel), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_size32(bus_size32),
    .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .cpu_halt(cpu_halt), .irq(irq)
  );

  int n_chk = 0, n_err = 0;
  bit summary_done = 1'b0;

  logic [31:0] m_src, m_dst, m_last, p_src, p_dst, first_rd;
  int          m_sstep, m_dstep, m_units, irq_cnt;
  bit          m_sz, got_first;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_f(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[31:16] + 16'h1357};
  endfunction

  function automatic int stp(input logic [1:0] mode, input bit wide);
    int s;
    s = wide ? 4 : 2;
    case (mode)
      2'b01:   return -s;
      2'b10:   return 0;
      default: return s;
    endcase
  endfunction

  function automatic logic [31:0] mk(input bit en, input bit ie, input logic [2:0] trg,
                                     input bit wide, input bit rpt, input logic [1:0] sm,
                                     input logic [1:0] dm, input logic [20:0] cnt);
    return {en, ie, trg, wide, rpt, sm, dm, cnt};
  endfunction

  always @(posedge clk) if (rst_n && irq) irq_cnt++;

  // bus responder and reference pointer model (R2, R3, R9, R10)
  always @(negedge clk) begin
    if (!rst_n || !bus_req || ($urandom_range(3) == 0)) begin
      bus_gnt = 1'b0;
    end else begin
      bus_gnt = 1'b1;
      chk(cpu_halt == 1'b1, "R9 halt high during access", cpu_halt, 1);
      chk(bus_size32 == m_sz, "R3 unit size flag", bus_size32, m_sz);
      if (!bus_we) begin
        chk(bus_addr == m_src, "R2 read address", bus_addr, m_src);
        bus_rdata = mem_f(bus_addr);
        m_last = bus_rdata;
        if (!got_first) begin first_rd = bus_addr; got_first = 1'b1; end
      end else begin
        chk(bus_addr == m_dst, "R2 write address", bus_addr, m_dst);
        chk(bus_wdata == m_last, "R10 write data equals read data", bus_wdata, m_last);
        m_src = m_src + 32'(m_sstep);
        m_dst = m_dst + 32'(m_dstep);
        m_units++;
      end
    end
  end

  task automatic wr_reg(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_sel = s; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic arm(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
    wr_reg(2'd0, s);
    wr_reg(2'd1, d);
    p_src = s; p_dst = d; m_src = s; m_dst = d;
    m_sz = c[26];
    m_sstep = stp(c[24:23], c[26]);
    m_dstep = stp(c[22:21], c[26]);
    m_units = 0; got_first = 1'b0;
    wr_reg(2'd2, c);
  endtask

  task automatic restart_model(input logic [31:0] c);
    if (c[24:23] == 2'b11) m_src = p_src;
    if (c[22:21] == 2'b11) m_dst = p_dst;
    got_first = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] s);
    @(negedge clk);
    trig_i = 1'b1; trig_sel = s;
    @(negedge clk);
    trig_i = 1'b0;
  endtask

  task automatic wait_burst(input string tag);
    int n;
    n = 0;
    while (!cpu_halt && n < 60) begin @(negedge clk); n++; end
    chk(cpu_halt == 1'b1, {tag, " burst began"}, cpu_halt, 1);
    n = 0;
    while (cpu_halt && n < 20000) begin @(negedge clk); n++; end
    chk(cpu_halt == 1'b0, {tag, " burst ended"}, cpu_halt, 0);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    int irq0;
    logic [31:0] c;
    void'($urandom(32'd20240611));
    irq_cnt = 0; m_units = 0; got_first = 1'b0;
    m_src = '0; m_dst = '0; m_last = '0; p_src = '0; p_dst = '0; first_rd = '0;
    m_sstep = 0; m_dstep = 0; m_sz = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk(cpu_halt == 1'b0, "R9 reset halt low", cpu_halt, 0);
    chk(bus_req == 1'b0, "R9 reset no request", bus_req, 0);
    chk(irq == 1'b0, "R7 reset irq low", irq, 0);
    chk(ctrl_rd == 32'h0, "R1 reset control word", ctrl_rd, 0);

    // immediate, 32-bit, up/up, 5 units, interrupt on
    irq0 = irq_cnt;
    c = mk(1, 1, 3'd0, 1, 0, 2'b00, 2'b00, 21'd5);
    arm(32'h1000_0000, 32'h2000_0100, c);
    wait_burst("R5 immediate");
    chk(m_units == 5, "R4 five units moved", m_units, 5);
    chk(irq_cnt - irq0 == 1, "R7 one interrupt", irq_cnt - irq0, 1);
    chk(ctrl_rd[31] == 1'b0, "R7 enable cleared", ctrl_rd[31], 0);

    // 16-bit, source down, destination fixed, no interrupt
    irq0 = irq_cnt;
    c = mk(1, 0, 3'd0, 0, 0, 2'b01, 2'b10, 21'd7);
    arm(32'h0300_0040, 32'h0400_0400, c);
    wait_burst("R2 down/fixed");
    chk(m_units == 7, "R4 seven units moved", m_units, 7);
    chk(irq_cnt == irq0, "R7 no interrupt when disabled", irq_cnt - irq0, 0);
    chk(m_src == 32'h0300_0032, "R2 source walked down", m_src, 32'h0300_0032);

    // zero count with bits above the field set means full range
    c = mk(1, 0, 3'd0, 0, 0, 2'b00, 2'b00, 21'h000200);
    arm(32'h0500_0000, 32'h0600_0000, c);
    wait_burst("R4 zero count");
    chk(m_units == 256, "R4 zero count gives 2^CNT_W units", m_units, 256);

    // triggered start, wrong trigger ignored, rewrite does not relatch
    irq0 = irq_cnt;
    c = mk(1, 1, 3'd3, 1, 0, 2'b00, 2'b00, 21'd4);
    arm(32'h0700_0000, 32'h0800_0000, c);
    repeat (30) @(negedge clk);
    chk(cpu_halt == 1'b0 && m_units == 0, "R5 waits for trigger", m_units, 0);
    pulse(3'd5);
    repeat (20) @(negedge clk);
    chk(cpu_halt == 1'b0 && m_units == 0, "R5 other trigger ignored", m_units, 0);
    wr_reg(2'd0, 32'h0900_0000);
    wr_reg(2'd2, c);
    pulse(3'd3);
    wait_burst("R5 matching trigger");
    chk(m_units == 4, "R5 four units after trigger", m_units, 4);
    chk(first_rd == 32'h0700_0000, "R1 pointer not relatched", first_rd, 32'h0700_0000);
    chk(irq_cnt - irq0 == 1, "R7 interrupt after triggered run", irq_cnt - irq0, 1);

    // repeat with reloading source and continuing destination
    irq0 = irq_cnt;
    c = mk(1, 1, 3'd2, 1, 1, 2'b11, 2'b00, 21'd3);
    arm(32'h0A00_0100, 32'h0B00_0000, c);
    restart_model(c);
    pulse(3'd2);
    wait_burst("R11 first run");
    chk(m_units == 3, "R11 first run count", m_units, 3);
    chk(ctrl_rd[31] == 1'b1, "R7 repeat keeps enable", ctrl_rd[31], 1);
    restart_model(c);
    m_units = 0;
    pulse(3'd2);
    wait_burst("R11 second run");
    chk(m_units == 3, "R11 fresh count on retrigger", m_units, 3);
    chk(first_rd == 32'h0A00_0100, "R2 reload on start", first_rd, 32'h0A00_0100);
    chk(m_dst == 32'h0B00_0018, "R2 destination continued", m_dst, 32'h0B00_0018);
    chk(irq_cnt - irq0 == 2, "R7 interrupt per completion", irq_cnt - irq0, 2);
    wr_reg(2'd2, 32'h0);

    // FIFO mode: capped bursts, trigger during a burst ignored
    irq0 = irq_cnt;
    c = mk(1, 1, 3'd7, 0, 0, 2'b00, 2'b00, 21'd250);
    arm(32'h0C00_0000, 32'h0D00_0000, c);
    pulse(3'd7);
    repeat (10) @(negedge clk);
    chk(cpu_halt == 1'b1, "R8 burst running before extra trigger", cpu_halt, 1);
    pulse(3'd7);
    wait_burst("R6 first burst");
    chk(m_units == 112, "R6 R8 first burst capped", m_units, 112);
    chk(irq_cnt == irq0, "R6 no interrupt mid transfer", irq_cnt - irq0, 0);
    chk(ctrl_rd[31] == 1'b1, "R6 enable kept mid transfer", ctrl_rd[31], 1);
    pulse(3'd7);
    wait_burst("R6 second burst");
    chk(m_units == 224, "R6 second burst capped", m_units, 224);
    pulse(3'd7);
    wait_burst("R6 last burst");
    chk(m_units == 250, "R6 R11 remainder resumed", m_units, 250);
    chk(irq_cnt - irq0 == 1, "R7 interrupt at end of FIFO transfer", irq_cnt - irq0, 1);
    chk(ctrl_rd[31] == 1'b0, "R7 enable cleared after FIFO", ctrl_rd[31], 0);

    // random immediate transfers across modes and sizes
    for (int i = 0; i < 24; i++) begin
      logic [1:0] sm, dm;
      bit wd, ie;
      int cnt;
      sm  = 2'($urandom_range(3));
      dm  = 2'($urandom_range(3));
      wd  = 1'($urandom_range(1));
      ie  = 1'($urandom_range(1));
      cnt = $urandom_range(1, 16);
      irq0 = irq_cnt;
      c = mk(1, ie, 3'd0, wd, 0, sm, dm, 21'(cnt));
      arm({8'h10 + 8'(i), 8'h00, 16'($urandom_range(255)) << 2},
          {8'h40 + 8'(i), 8'h00, 16'($urandom_range(255)) << 2}, c);
      wait_burst("R2 R3 random");
      chk(m_units == cnt, "R4 random count", m_units, cnt);
      chk(irq_cnt - irq0 == int'(ie), "R7 random interrupt", irq_cnt - irq0, ie);
      chk(ctrl_rd[31] == 1'b0, "R7 random enable cleared", ctrl_rd[31], 0);
    end

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule